// File: doc/BRIEF.md
# Three-Format Instruction Field Decoder

This block takes one fixed-width 32-bit instruction word of a three-operand load-store instruction set. It splits the word into its fields and produces the control strobes that an execute stage needs. The format is chosen by the 6-bit operation code in bits 31:26. Code 000000 marks a register-type word, and the operation is then picked by the 6-bit function code in bits 5:0. Codes 000010 and 000011 mark jump-type words, which carry a 26-bit target. Every other code is treated as an immediate-type word with a 16-bit immediate in bits 15:0.

The word presented on `instr_i` is registered together with everything derived from it. All outputs therefore describe the word sampled at the previous rising clock edge. The supported subset covers:

- register-type: add, sub, and, or, slt and jr
- immediate-type: addi, slti, lui, lw, lb, sw, sb, beq and bne
- jump-type: j and jal

Any other encoding raises an illegal flag and keeps every strobe that could change machine state low.

Top module: `instr_field_decoder`

## Requirements
- R1: While `rst_n` is low, every output is zero.
- R2: Outputs change only at a rising clock edge. They describe the instruction word sampled at that edge, so the latency is one cycle.
- R3: The raw fields come from fixed bit positions of the word:
  - opcode from bits 31:26
  - rs from 25:21
  - rt from 20:16
  - rd from 15:11
  - shamt from 10:6
  - funct from 5:0
  - target from 25:0
- R4: `imm_o` is bits 15:0 of the word, sign-extended from bit 15 to 32 bits, for every word.
- R5: `fmt_o` is 0 when the opcode is 000000 (register-type) and 2 when the opcode is 000010 or 000011 (jump-type). It is 1 for every other opcode (immediate-type).
- R6: With opcode 000000, the function codes 100000 add, 100010 sub, 100100 and, 100101 or and 101010 slt produce the following:
  - register write set, with `dst_sel_o`=1 (rd)
  - register operand source (`alu_src_imm_o`=0)
  - write-back from the ALU (`wb_sel_o`=0)
  - `alu_op_o` of 0, 1, 2, 3 and 4 respectively
- R7: Opcode 000000 with function code 001000 (jr) sets only `jump_reg_o`. It leaves the register write and the memory strobes low.
- R8: Opcodes 001000 addi, 001010 slti and 001111 lui produce the following:
  - register write to rt (`dst_sel_o`=0)
  - immediate source (`alu_src_imm_o`=1)
  - write-back from the ALU
  - `alu_op_o` of 0, 4 and 5 respectively
- R9: Memory operations use `alu_op_o`=0 (add) and the immediate source. Opcodes 100011 lw and 100000 lb set the memory read and write rt with `wb_sel_o`=1 (memory). Opcodes 101011 sw and 101000 sb set the memory write with no register write. `mem_byte_o` is set for lb and sb only.
- R10: Opcodes 000100 beq and 000101 bne set `branch_o` with `alu_op_o`=1 (subtract). `branch_ne_o` is set for bne only, and no register or memory write occurs.
- R11: Opcode 000010 j sets `jump_o` only. Opcode 000011 jal sets the following:
  - `jump_o`, `link_o` and the register write
  - `dst_sel_o`=2 with `dst_reg_o`=31
  - `wb_sel_o`=2 (return address PC+4)
- R12: Any opcode outside the subset, and any function code outside the subset under opcode 000000, sets `illegal_o`. Every control strobe and select output is then zero.
- R13: `dst_reg_o` equals rt when `dst_sel_o` is 0, rd when it is 1, and 31 when it is 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_i | input | 32 | Instruction word to decode |
| fmt_o | output | 2 | Format: 0 register, 1 immediate, 2 jump |
| opcode_o | output | 6 | Operation code field |
| rs_o | output | 5 | First source register field |
| rt_o | output | 5 | Second source / immediate destination field |
| rd_o | output | 5 | Register-type destination field |
| shamt_o | output | 5 | Shift amount field |
| funct_o | output | 6 | Function code field |
| imm_o | output | 32 | Sign-extended 16-bit immediate |
| target_o | output | 26 | Jump target field |
| dst_reg_o | output | 5 | Resolved destination register index |
| reg_write_o | output | 1 | Register file write enable |
| dst_sel_o | output | 2 | Destination select: 0 rt, 1 rd, 2 register 31 |
| alu_src_imm_o | output | 1 | Second ALU operand is the immediate |
| alu_op_o | output | 4 | 0 add, 1 sub, 2 and, 3 or, 4 set-less-than, 5 load-upper |
| mem_read_o | output | 1 | Memory read |
| mem_write_o | output | 1 | Memory write |
| mem_byte_o | output | 1 | Memory access is one byte |
| branch_o | output | 1 | Conditional branch |
| branch_ne_o | output | 1 | Branch condition is not-equal |
| jump_o | output | 1 | Jump to the 26-bit target |
| jump_reg_o | output | 1 | Jump to the address held in rs |
| link_o | output | 1 | Return address is written |
| wb_sel_o | output | 2 | Write-back source: 0 ALU, 1 memory, 2 PC+4 |
| illegal_o | output | 1 | Encoding outside the supported subset |

## Verification
The hardest cases to reach are the illegal function codes hidden under the register-type opcode. They share the opcode with five legal arithmetic codes and with jr, so only a sweep of all 64 function values separates them. The bench therefore walks every one of the 64 opcodes against every one of the 64 values of the low six bits. The remaining 20 bits are filled from a multiplicative hash, so the immediate sign bit, rd, rt and rs all change from vector to vector. A short directed pass then pins the immediate at both sign boundaries and shows the one-cycle delay.

// File: rtl/instr_field_decoder_pkg.sv
package instr_field_decoder_pkg;

    localparam int WORD_W   = 32;
    localparam int OPC_W    = 6;
    localparam int REG_W    = 5;
    localparam int FUNCT_W  = 6;
    localparam int IMM_W    = 16;
    localparam int TARGET_W = WORD_W - OPC_W;
    localparam int ALU_W    = 4;

    localparam logic [REG_W-1:0] LINK_REG = REG_W'(31);

    // operation codes
    localparam logic [OPC_W-1:0] OP_REG  = 6'b000000;
    localparam logic [OPC_W-1:0] OP_J    = 6'b000010;
    localparam logic [OPC_W-1:0] OP_JAL  = 6'b000011;
    localparam logic [OPC_W-1:0] OP_BEQ  = 6'b000100;
    localparam logic [OPC_W-1:0] OP_BNE  = 6'b000101;
    localparam logic [OPC_W-1:0] OP_ADDI = 6'b001000;
    localparam logic [OPC_W-1:0] OP_SLTI = 6'b001010;
    localparam logic [OPC_W-1:0] OP_LUI  = 6'b001111;
    localparam logic [OPC_W-1:0] OP_LB   = 6'b100000;
    localparam logic [OPC_W-1:0] OP_LW   = 6'b100011;
    localparam logic [OPC_W-1:0] OP_SB   = 6'b101000;
    localparam logic [OPC_W-1:0] OP_SW   = 6'b101011;

    // function codes under OP_REG
    localparam logic [FUNCT_W-1:0] FN_JR  = 6'b001000;
    localparam logic [FUNCT_W-1:0] FN_ADD = 6'b100000;
    localparam logic [FUNCT_W-1:0] FN_SUB = 6'b100010;
    localparam logic [FUNCT_W-1:0] FN_AND = 6'b100100;
    localparam logic [FUNCT_W-1:0] FN_OR  = 6'b100101;
    localparam logic [FUNCT_W-1:0] FN_SLT = 6'b101010;

    typedef enum logic [1:0] {FMT_REG = 2'd0, FMT_IMM = 2'd1, FMT_JMP = 2'd2} fmt_e;
    typedef enum logic [1:0] {DST_RT = 2'd0, DST_RD = 2'd1, DST_LINK = 2'd2} dst_e;
    typedef enum logic [1:0] {WB_ALU = 2'd0, WB_MEM = 2'd1, WB_PC4 = 2'd2} wb_e;
    typedef enum logic [ALU_W-1:0] {
        ALU_ADD = 4'd0, ALU_SUB = 4'd1, ALU_AND = 4'd2,
        ALU_OR  = 4'd3, ALU_SLT = 4'd4, ALU_LUI = 4'd5
    } alu_e;

    typedef struct packed {
        fmt_e                fmt;
        logic [OPC_W-1:0]    opcode;
        logic [REG_W-1:0]    rs;
        logic [REG_W-1:0]    rt;
        logic [REG_W-1:0]    rd;
        logic [REG_W-1:0]    shamt;
        logic [FUNCT_W-1:0]  funct;
        logic [WORD_W-1:0]   imm;
        logic [TARGET_W-1:0] target;
    } fields_t;

    typedef struct packed {
        logic reg_write;
        dst_e dst_sel;
        logic alu_src_imm;
        alu_e alu_op;
        logic mem_read;
        logic mem_write;
        logic mem_byte;
        logic branch;
        logic branch_ne;
        logic jump;
        logic jump_reg;
        logic link;
        wb_e  wb_sel;
        logic illegal;
    } ctrl_t;

    typedef struct packed {
        fields_t          f;
        ctrl_t            c;
        logic [REG_W-1:0] dst_reg;
    } dec_out_t;

endpackage

// File: rtl/instr_field_splitter.sv
module instr_field_splitter
    import instr_field_decoder_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    output fields_t           fields_o
);
    localparam int OPC_LSB   = WORD_W - OPC_W;
    localparam int RS_LSB    = OPC_LSB - REG_W;
    localparam int RT_LSB    = RS_LSB - REG_W;
    localparam int RD_LSB    = RT_LSB - REG_W;
    localparam int SHAMT_LSB = RD_LSB - REG_W;

    logic [OPC_W-1:0] opc;

    always_comb begin
        opc                = word_i[WORD_W-1 -: OPC_W];
        fields_o.opcode    = opc;
        fields_o.rs        = word_i[RS_LSB +: REG_W];
        fields_o.rt        = word_i[RT_LSB +: REG_W];
        fields_o.rd        = word_i[RD_LSB +: REG_W];
        fields_o.shamt     = word_i[SHAMT_LSB +: REG_W];
        fields_o.funct     = word_i[FUNCT_W-1:0];
        fields_o.imm       = {{(WORD_W-IMM_W){word_i[IMM_W-1]}}, word_i[IMM_W-1:0]};
        fields_o.target    = word_i[TARGET_W-1:0];
        if (opc == OP_REG)
            fields_o.fmt = FMT_REG;
        else if (opc == OP_J || opc == OP_JAL)
            fields_o.fmt = FMT_JMP;
        else
            fields_o.fmt = FMT_IMM;
    end
endmodule

// File: rtl/instr_ctrl_decoder.sv
module instr_ctrl_decoder
    import instr_field_decoder_pkg::*;
(
    input  logic [OPC_W-1:0]   opcode_i,
    input  logic [FUNCT_W-1:0] funct_i,
    output ctrl_t              ctrl_o
);
    ctrl_t c;

    always_comb begin
        c = '0;
        unique case (opcode_i)
            OP_REG: begin
                c.reg_write = 1'b1;
                c.dst_sel   = DST_RD;
                unique case (funct_i)
                    FN_ADD:  c.alu_op = ALU_ADD;
                    FN_SUB:  c.alu_op = ALU_SUB;
                    FN_AND:  c.alu_op = ALU_AND;
                    FN_OR:   c.alu_op = ALU_OR;
                    FN_SLT:  c.alu_op = ALU_SLT;
                    FN_JR: begin
                        c          = '0;
                        c.jump_reg = 1'b1;
                    end
                    default: c.illegal = 1'b1;
                endcase
            end
            OP_ADDI, OP_SLTI, OP_LUI: begin
                c.reg_write   = 1'b1;
                c.alu_src_imm = 1'b1;
                c.alu_op      = (opcode_i == OP_ADDI) ? ALU_ADD :
                                (opcode_i == OP_SLTI) ? ALU_SLT : ALU_LUI;
            end
            OP_LW, OP_LB: begin
                c.reg_write   = 1'b1;
                c.alu_src_imm = 1'b1;
                c.mem_read    = 1'b1;
                c.mem_byte    = (opcode_i == OP_LB);
                c.wb_sel      = WB_MEM;
            end
            OP_SW, OP_SB: begin
                c.alu_src_imm = 1'b1;
                c.mem_write   = 1'b1;
                c.mem_byte    = (opcode_i == OP_SB);
            end
            OP_BEQ, OP_BNE: begin
                c.branch    = 1'b1;
                c.branch_ne = (opcode_i == OP_BNE);
                c.alu_op    = ALU_SUB;
            end
            OP_J:   c.jump = 1'b1;
            OP_JAL: begin
                c.jump      = 1'b1;
                c.link      = 1'b1;
                c.reg_write = 1'b1;
                c.dst_sel   = DST_LINK;
                c.wb_sel    = WB_PC4;
            end
            default: c.illegal = 1'b1;
        endcase
        // an unknown encoding must leave no strobe behind
        if (c.illegal) begin
            c         = '0;
            c.illegal = 1'b1;
        end
        ctrl_o = c;
    end
endmodule

// File: rtl/instr_field_decoder.sv
module instr_field_decoder
    import instr_field_decoder_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [WORD_W-1:0]   instr_i,
    output logic [1:0]          fmt_o,
    output logic [OPC_W-1:0]    opcode_o,
    output logic [REG_W-1:0]    rs_o,
    output logic [REG_W-1:0]    rt_o,
    output logic [REG_W-1:0]    rd_o,
    output logic [REG_W-1:0]    shamt_o,
    output logic [FUNCT_W-1:0]  funct_o,
    output logic [WORD_W-1:0]   imm_o,
    output logic [TARGET_W-1:0] target_o,
    output logic [REG_W-1:0]    dst_reg_o,
    output logic                reg_write_o,
    output logic [1:0]          dst_sel_o,
    output logic                alu_src_imm_o,
    output logic [ALU_W-1:0]    alu_op_o,
    output logic                mem_read_o,
    output logic                mem_write_o,
    output logic                mem_byte_o,
    output logic                branch_o,
    output logic                branch_ne_o,
    output logic                jump_o,
    output logic                jump_reg_o,
    output logic                link_o,
    output logic [1:0]          wb_sel_o,
    output logic                illegal_o
);
    fields_t  fields;
    ctrl_t    ctrl;
    dec_out_t out_d, out_q;

    instr_field_splitter split_i (
        .word_i   (instr_i),
        .fields_o (fields)
    );

    instr_ctrl_decoder ctrl_i (
        .opcode_i (fields.opcode),
        .funct_i  (fields.funct),
        .ctrl_o   (ctrl)
    );

    always_comb begin
        out_d.f = fields;
        out_d.c = ctrl;
        unique case (ctrl.dst_sel)
            DST_RD:   out_d.dst_reg = fields.rd;
            DST_LINK: out_d.dst_reg = LINK_REG;
            default:  out_d.dst_reg = fields.rt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign fmt_o         = out_q.f.fmt;
    assign opcode_o      = out_q.f.opcode;
    assign rs_o          = out_q.f.rs;
    assign rt_o          = out_q.f.rt;
    assign rd_o          = out_q.f.rd;
    assign shamt_o       = out_q.f.shamt;
    assign funct_o       = out_q.f.funct;
    assign imm_o         = out_q.f.imm;
    assign target_o      = out_q.f.target;
    assign dst_reg_o     = out_q.dst_reg;
    assign reg_write_o   = out_q.c.reg_write;
    assign dst_sel_o     = out_q.c.dst_sel;
    assign alu_src_imm_o = out_q.c.alu_src_imm;
    assign alu_op_o      = out_q.c.alu_op;
    assign mem_read_o    = out_q.c.mem_read;
    assign mem_write_o   = out_q.c.mem_write;
    assign mem_byte_o    = out_q.c.mem_byte;
    assign branch_o      = out_q.c.branch;
    assign branch_ne_o   = out_q.c.branch_ne;
    assign jump_o        = out_q.c.jump;
    assign jump_reg_o    = out_q.c.jump_reg;
    assign link_o        = out_q.c.link;
    assign wb_sel_o      = out_q.c.wb_sel;
    assign illegal_o     = out_q.c.illegal;
endmodule

// File: rtl/instr_field_decoder_chk.sv
module instr_field_decoder_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] instr_i,
    input logic [1:0]  fmt_o,
    input logic [4:0]  rs_o,
    input logic [4:0]  rt_o,
    input logic [4:0]  rd_o,
    input logic [31:0] imm_o,
    input logic [4:0]  dst_reg_o,
    input logic        reg_write_o,
    input logic [1:0]  dst_sel_o,
    input logic        mem_read_o,
    input logic        mem_write_o,
    input logic        branch_o,
    input logic        jump_o,
    input logic        jump_reg_o,
    input logic        link_o,
    input logic [1:0]  wb_sel_o,
    input logic        illegal_o
);
    logic primed_q;
    always_ff @(posedge clk) begin
        if (!rst_n) primed_q <= 1'b0;
        else        primed_q <= 1'b1;
    end

    assert_fields_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        primed_q |-> (rs_o == $past(instr_i[25:21]) && rt_o == $past(instr_i[20:16])
                      && rd_o == $past(instr_i[15:11])));

    assert_imm_sign_R4: assert property (@(posedge clk) disable iff (!rst_n)
        imm_o[31:16] == {16{imm_o[15]}});

    assert_reg_format_R5: assert property (@(posedge clk) disable iff (!rst_n)
        primed_q |-> (($past(instr_i[31:26]) == 6'd0) == (fmt_o == 2'd0)));

    assert_mem_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_read_o && mem_write_o));

    assert_link_dest_R11: assert property (@(posedge clk) disable iff (!rst_n)
        link_o |-> (dst_reg_o == 5'd31 && reg_write_o && wb_sel_o == 2'd2 && jump_o));

    assert_illegal_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> !(reg_write_o || mem_read_o || mem_write_o || branch_o
                        || jump_o || jump_reg_o || link_o));

    assert_dst_resolve_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (dst_sel_o == 2'd1) |-> (dst_reg_o == rd_o));
endmodule

bind instr_field_decoder instr_field_decoder_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_i     (instr_i),
    .fmt_o       (fmt_o),
    .rs_o        (rs_o),
    .rt_o        (rt_o),
    .rd_o        (rd_o),
    .imm_o       (imm_o),
    .dst_reg_o   (dst_reg_o),
    .reg_write_o (reg_write_o),
    .dst_sel_o   (dst_sel_o),
    .mem_read_o  (mem_read_o),
    .mem_write_o (mem_write_o),
    .branch_o    (branch_o),
    .jump_o      (jump_o),
    .jump_reg_o  (jump_reg_o),
    .link_o      (link_o),
    .wb_sel_o    (wb_sel_o),
    .illegal_o   (illegal_o)
);

// File: tb/instr_field_decoder_tb_top.sv
module instr_field_decoder_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] instr = '0;

    logic [1:0]  fmt;
    logic [5:0]  opcode, funct;
    logic [4:0]  rs, rt, rd, shamt, dst_reg;
    logic [31:0] imm;
    logic [25:0] target;
    logic        reg_write, alu_src_imm, mem_read, mem_write, mem_byte;
    logic        branch, branch_ne, jump, jump_reg, link, illegal;
    logic [1:0]  dst_sel, wb_sel;
    logic [3:0]  alu_op;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    instr_field_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .instr_i(instr),
        .fmt_o(fmt), .opcode_o(opcode), .rs_o(rs), .rt_o(rt), .rd_o(rd),
        .shamt_o(shamt), .funct_o(funct), .imm_o(imm), .target_o(target),
        .dst_reg_o(dst_reg), .reg_write_o(reg_write), .dst_sel_o(dst_sel),
        .alu_src_imm_o(alu_src_imm), .alu_op_o(alu_op), .mem_read_o(mem_read),
        .mem_write_o(mem_write), .mem_byte_o(mem_byte), .branch_o(branch),
        .branch_ne_o(branch_ne), .jump_o(jump), .jump_reg_o(jump_reg),
        .link_o(link), .wb_sel_o(wb_sel), .illegal_o(illegal)
    );

    // {reg_write, dst_sel, alu_src_imm, alu_op, mem_read, mem_write, mem_byte,
    //  branch, branch_ne, jump, jump_reg, link, wb_sel, illegal}
    function automatic logic [18:0] pack_ctrl(logic rw, logic [1:0] ds, logic ai,
        logic [3:0] ao, logic mr, logic mw, logic mb, logic br, logic bn,
        logic jp, logic jr, logic lk, logic [1:0] wb, logic il);
        return {rw, ds, ai, ao, mr, mw, mb, br, bn, jp, jr, lk, wb, il};
    endfunction

    // Spec model of the requirements; tag names the requirement checked
    function automatic logic [18:0] expect_ctrl(logic [5:0] op, logic [5:0] fn,
                                                output string tag);
        tag = "R12";
        case (op)
            6'h00: case (fn)
                6'h20: begin tag = "R6"; return pack_ctrl(1,1,0,0,0,0,0,0,0,0,0,0,0,0); end
                6'h22: begin tag = "R6"; return pack_ctrl(1,1,0,1,0,0,0,0,0,0,0,0,0,0); end
                6'h24: begin tag = "R6"; return pack_ctrl(1,1,0,2,0,0,0,0,0,0,0,0,0,0); end
                6'h25: begin tag = "R6"; return pack_ctrl(1,1,0,3,0,0,0,0,0,0,0,0,0,0); end
                6'h2a: begin tag = "R6"; return pack_ctrl(1,1,0,4,0,0,0,0,0,0,0,0,0,0); end
                6'h08: begin tag = "R7"; return pack_ctrl(0,0,0,0,0,0,0,0,0,0,1,0,0,0); end
                default: return pack_ctrl(0,0,0,0,0,0,0,0,0,0,0,0,0,1);
            endcase
            6'h08: begin tag = "R8";  return pack_ctrl(1,0,1,0,0,0,0,0,0,0,0,0,0,0); end
            6'h0a: begin tag = "R8";  return pack_ctrl(1,0,1,4,0,0,0,0,0,0,0,0,0,0); end
            6'h0f: begin tag = "R8";  return pack_ctrl(1,0,1,5,0,0,0,0,0,0,0,0,0,0); end
            6'h23: begin tag = "R9";  return pack_ctrl(1,0,1,0,1,0,0,0,0,0,0,0,1,0); end
            6'h20: begin tag = "R9";  return pack_ctrl(1,0,1,0,1,0,1,0,0,0,0,0,1,0); end
            6'h2b: begin tag = "R9";  return pack_ctrl(0,0,1,0,0,1,0,0,0,0,0,0,0,0); end
            6'h28: begin tag = "R9";  return pack_ctrl(0,0,1,0,0,1,1,0,0,0,0,0,0,0); end
            6'h04: begin tag = "R10"; return pack_ctrl(0,0,0,1,0,0,0,1,0,0,0,0,0,0); end
            6'h05: begin tag = "R10"; return pack_ctrl(0,0,0,1,0,0,0,1,1,0,0,0,0,0); end
            6'h02: begin tag = "R11"; return pack_ctrl(0,0,0,0,0,0,0,0,0,1,0,0,0,0); end
            6'h03: begin tag = "R11"; return pack_ctrl(1,2,0,0,0,0,0,0,0,1,0,1,2,0); end
            default: return pack_ctrl(0,0,0,0,0,0,0,0,0,0,0,0,0,1);
        endcase
    endfunction

    task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [18:0] dut_ctrl();
        return {reg_write, dst_sel, alu_src_imm, alu_op, mem_read, mem_write, mem_byte,
                branch, branch_ne, jump, jump_reg, link, wb_sel, illegal};
    endfunction

    // apply at the falling edge, sample at the next falling edge (one register)
    task automatic apply_and_check(logic [31:0] w);
        string       tag;
        logic [18:0] ec;
        logic [1:0]  ef;
        logic [4:0]  ed;
        instr = w;
        @(negedge clk);
        check({opcode, rs, rt, rd, shamt, funct, target} ==
              {w[31:26], w[25:21], w[20:16], w[15:11], w[10:6], w[5:0], w[25:0]},
              "R3", "fields", {opcode, rs, rt, rd}, {w[31:26], w[25:21], w[20:16], w[15:11]});
        check(imm == {{16{w[15]}}, w[15:0]}, "R4", "imm", imm, {{16{w[15]}}, w[15:0]});
        ef = (w[31:26] == 6'd0) ? 2'd0 : (w[31:27] == 5'b00001) ? 2'd2 : 2'd1;
        check(fmt == ef, "R5", "fmt", fmt, ef);
        ec = expect_ctrl(w[31:26], w[5:0], tag);
        check(dut_ctrl() == ec, tag, "ctrl", dut_ctrl(), ec);
        ed = (ec[17:16] == 2'd1) ? w[15:11] : (ec[17:16] == 2'd2) ? 5'd31 : w[20:16];
        check(dst_reg == ed, (ec[17:16] == 2'd2) ? "R11" : "R13", "dst_reg", dst_reg, ed);
    endtask

    initial begin
        instr = 32'hFFFF_FFFF;
        repeat (3) @(negedge clk);
        check(dut_ctrl() == '0 && {fmt, opcode, rs, rt, rd, imm, target, dst_reg} == '0,
              "R1", "reset state", dut_ctrl(), 0);
        rst_n = 1'b1;

        // one-cycle latency: before the edge the old word is still shown
        instr = {6'h23, 5'd4, 5'd9, 16'h0010};
        @(negedge clk);
        instr = {6'h2b, 5'd1, 5'd2, 16'h0020};
        #1;
        check(mem_read && !mem_write && rt == 5'd9, "R2", "hold before edge",
              {mem_read, mem_write}, 2'b10);
        @(negedge clk);
        check(!mem_read && mem_write && rt == 5'd2, "R2", "update after edge",
              {mem_read, mem_write}, 2'b01);

        // immediate sign boundaries
        apply_and_check({6'h08, 5'd3, 5'd5, 16'h8000});
        apply_and_check({6'h08, 5'd3, 5'd5, 16'h7FFF});
        apply_and_check({6'h0f, 5'd0, 5'd7, 16'hFFFF});
        apply_and_check({6'h03, 26'h3FF_FFFF});

        // full opcode x low-six-bit sweep with hashed middle bits
        for (int op = 0; op < 64; op++) begin
            for (int s = 0; s < 64; s++) begin
                logic [31:0] h;
                h = 32'(op) * 32'h9E37_79B1 ^ 32'(s) * 32'h0000_9E3D ^ 32'h5A5A_C3C3;
                apply_and_check({op[5:0], h[19:0], s[5:0]});
            end
        end

        // reset drives outputs back to zero
        instr = {6'h03, 26'h0};
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(dut_ctrl() == '0 && dst_reg == '0, "R1", "re-reset", dut_ctrl(), 0);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (50000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule